// File: doc/BRIEF.md
# Sector Protection Command Sequencer

This block runs the write-protect and verify procedure for the sectors of a flash array. It only responds while `hv_mode` is high, which stands for the elevated-voltage level being applied on the device's reset line. While in this mode the host issues bus writes and reads. A set-up write moves the sequencer forward. A protect write carrying a sector address and a fixed low-address pattern starts a timed protect operation. A verify write selects a sector whose protection bit is then returned on bit 0 of read data.

One protection bit is held per sector. A protect operation sets the bit only when its busy window completes. If a verify read returns 0, the host reissues the protect write straight from the verify state and tries again. Clearing `hv_mode` drops the sequencer out of the mode at the next clock edge and cancels any protect operation still in flight. The protection bits themselves persist until the separate power-on reset `por_n` is asserted.

Top module: `sector_lock_seq`

## Requirements
- R1: With `por_n` low at a clock edge, all protection bits clear, `busy` goes low and the sequencer leaves the mode; a read then returns 8'h00.
- R2: While `hv_mode` is low, writes have no effect: `busy` stays low and no protection bit changes.
- R3: In the idle-in-mode state, a write of 8'h60 to any address enters set-up. A following write of 8'h60 with a qualifying address to a sector below NUM_SECT raises `busy` after that edge. `busy` stays high for exactly PROT_CYCLES cycles, and the sector's bit is set when it falls.
- R4: An address qualifies when A6=0, A1=1, A0=0. The sector number is taken from addr[AW-1:SECT_LSB]. In set-up, a write with a different code, a non-qualifying address or a sector number of NUM_SECT or above returns the sequencer to idle and changes no bit. A verify write issued while idle is ignored.
- R5: After a protect completes, a write of 8'h40 with a qualifying address enters verify for that sector. A read (`rd_en` high) then returns bit 0 equal to the sector's protection bit and bits 7:1 zero, in the same cycle. Another qualifying 8'h40 in verify selects a new sector.
- R6: In verify, a qualifying 8'h60 write starts a protect operation directly (retry), with the same busy length as R3.
- R7: Writes made while `busy` is high are ignored: they change neither the busy length nor any other sector's bit.
- R8: When `hv_mode` falls, the sequencer leaves the mode at the next edge and `busy` drops. An interrupted protect leaves its bit clear. On re-entry the sequencer starts from idle.
- R9: Protection bits survive leaving and re-entering the mode; only `por_n` clears them.
- R10: A read while not in verify returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; clears protection bits |
| hv_mode | input | 1 | High while the elevated-voltage mode level is applied |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW | Bus address; upper field is the sector, A6/A1/A0 qualify |
| wdata | input | 8 | Command code of a write |
| rdata | output | 8 | Read data; bit 0 is verify status |
| busy | output | 1 | High while a protect operation runs |

## Verification
A write takes effect at the clock edge where `wr_en` is sampled. The bench drives each write at a falling edge, and the following falling edge is the first point where `busy` can be observed high. From that point it counts falling edges until `busy` drops and expects exactly PROT_CYCLES. Read data is combinational from `rd_en`, so the bench raises `rd_en` on a falling edge and samples `rdata` shortly afterwards, with no clock edge in between. After `hv_mode` falls, the first falling edge that follows the next rising edge must show `busy` low.

// File: rtl/sector_lock_seq.sv
module sector_lock_seq #(
  parameter int NUM_SECT    = 19,
  parameter int AW          = 20,
  parameter int SECT_LSB    = 12,
  parameter int PROT_CYCLES = 250
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hv_mode,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam int IW = AW - SECT_LSB;
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int CW = $clog2(PROT_CYCLES + 1);

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_SETUP, S_BUSY, S_READY, S_VERIFY} st_t;

  st_t                 st;
  logic [NUM_SECT-1:0] prot;
  logic [CW-1:0]       cnt;
  logic [SW-1:0]       tsect;

  wire [IW-1:0] idx     = addr[AW-1:SECT_LSB];
  wire          qual    = !addr[6] && addr[1] && !addr[0] && (32'(idx) < NUM_SECT);
  wire          c_setup = (wdata == 8'h60);
  wire          c_check = (wdata == 8'h40);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st    <= S_OFF;
      prot  <= '0;
      cnt   <= '0;
      tsect <= '0;
    end else if (!hv_mode) begin
      st <= S_OFF;
    end else begin
      case (st)
        S_OFF: st <= S_IDLE;
        S_BUSY:
          if (cnt == '0) begin
            prot[tsect] <= 1'b1;
            st          <= S_READY;
          end else begin
            cnt <= cnt - 1'b1;
          end
        default:
          if (wr_en) begin
            if (st == S_IDLE) begin
              st <= c_setup ? S_SETUP : S_IDLE;
            end else if (c_setup && qual && (st == S_SETUP || st == S_VERIFY)) begin
              st    <= S_BUSY;
              cnt   <= CW'(PROT_CYCLES - 1);
              tsect <= idx[SW-1:0];
            end else if (c_check && qual && (st == S_READY || st == S_VERIFY)) begin
              st    <= S_VERIFY;
              tsect <= idx[SW-1:0];
            end else begin
              st <= S_IDLE;
            end
          end
      endcase
    end
  end

  assign busy  = (st == S_BUSY);
  assign rdata = {7'b0, rd_en && (st == S_VERIFY) && prot[tsect]};

  a_r1_por_clears: assert property (@(posedge clk)
    !por_n |=> (prot == '0 && !busy));

  a_r8_exit_mode: assert property (@(posedge clk) disable iff (!por_n)
    !hv_mode |=> (!busy && st == S_OFF));

  a_r9_bits_sticky: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (($past(prot) & ~prot) == '0));

  a_r3_set_after_busy: assert property (@(posedge clk) disable iff (!por_n)
    ($countones(prot) > $countones($past(prot))) |-> $past(busy));

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!por_n)
    (busy && hv_mode && cnt != '0) |=> busy);

  a_r6_retry_starts: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_VERIFY && hv_mode && wr_en && c_setup && qual) |=> busy);

  a_r10_read_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (st != S_VERIFY) |-> (rdata == 8'h00));
endmodule

// File: tb/test_sector_lock_seq.sv
module test_sector_lock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 19;
  localparam int AW  = 20;
  localparam int SL  = 12;
  localparam int PC  = 16;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          hv_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit exp_prot [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_lock_seq #(.NUM_SECT(NS), .AW(AW), .SECT_LSB(SL), .PROT_CYCLES(PC)) i_sector_lock_seq (
    .clk(clk), .por_n(por_n), .hv_mode(hv_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  function automatic logic [AW-1:0] mk(int s, bit q);
    logic [AW-1:0] a;
    a = AW'(s) << SL;
    a[1] = 1'b1;
    if (!q) a[6] = 1'b1;
    return a;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int exp, string tag);
    rd_en = 1'b1;
    #1;
    chk(int'(rdata), exp, tag);
    rd_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic protect(int s, bit q, logic [7:0] code, int exp_len, string tag);
    int n;
    wr('0, 8'hF0);
    wr('0, 8'h60);
    wr(mk(s, q), code);
    busy_len(n);
    chk(n, exp_len, tag);
  endtask

  task automatic verify(int s, int exp, string tag);
    wr(mk(s, 1'b1), 8'h40);
    rd_chk(exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    foreach (exp_prot[i]) exp_prot[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(busy), 0, "R1 busy in reset");
    rd_chk(0, "R1 read in reset");
    por_n = 1'b1;

    // R2: writes outside the mode do nothing
    protect(3, 1'b1, 8'h60, 0, "R2 no busy outside mode");
    hv_mode = 1'b1;
    protect(4, 1'b1, 8'h60, PC, "R3 busy length sect4");
    verify(3, 0, "R2 sect3 untouched");

    // R3/R5 basic protect and verify
    protect(2, 1'b1, 8'h60, PC, "R3 busy length sect2");
    exp_prot[2] = 1; exp_prot[4] = 1;
    verify(2, 1, "R5 verify sect2");
    verify(5, 0, "R5 failed verify sect5");

    // R6 retry from verify
    wr(mk(5, 1'b1), 8'h60);
    busy_len(n);
    chk(n, PC, "R6 retry busy length");
    exp_prot[5] = 1;
    verify(5, 1, "R6 retry verify sect5");

    // R4 bad qualifier, out-of-range sector, bad code
    protect(7, 1'b0, 8'h60, 0, "R4 bad qualifier no busy");
    wr(mk(7, 1'b1), 8'h40);
    rd_chk(0, "R4 verify in idle ignored");
    protect(NS, 1'b1, 8'h60, 0, "R4 sector out of range");
    protect(8, 1'b1, 8'h61, 0, "R4 wrong code");
    rd_chk(0, "R10 read outside verify");

    // R7 writes during busy ignored
    wr('0, 8'hF0);
    wr('0, 8'h60);
    wr(mk(9, 1'b1), 8'h60);
    n = 1;
    @(negedge clk); n++;
    wr_en = 1'b1; addr = mk(10, 1'b1); wdata = 8'h60;
    @(negedge clk); n++;
    wdata = 8'hF0;
    @(negedge clk); n++;
    wr_en = 1'b0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n - 1, PC, "R7 busy length with writes");
    exp_prot[9] = 1;
    verify(10, 0, "R7 sect10 not protected");
    verify(9, 1, "R7 sect9 protected");

    // R8 abort on mode exit
    wr('0, 8'hF0);
    wr('0, 8'h60);
    wr(mk(11, 1'b1), 8'h60);
    repeat (3) @(negedge clk);
    hv_mode = 1'b0;
    @(negedge clk);
    chk(int'(busy), 0, "R8 busy drops on exit");
    hv_mode = 1'b1;
    protect(12, 1'b1, 8'h60, PC, "R8 protect after reentry");
    exp_prot[12] = 1;
    verify(11, 0, "R8 aborted sector clear");

    // R9 persistence and power-on clear
    hv_mode = 1'b0;
    repeat (2) @(negedge clk);
    hv_mode = 1'b1;
    protect(0, 1'b1, 8'h60, PC, "R9 protect sect0");
    exp_prot[0] = 1;
    verify(2, 1, "R9 sect2 survives exit");
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    chk(int'(busy), 0, "R1 busy after por");
    por_n = 1'b1;
    foreach (exp_prot[i]) exp_prot[i] = 1'b0;
    protect(1, 1'b1, 8'h60, PC, "R1 protect after por");
    exp_prot[1] = 1;
    verify(2, 0, "R9 por clears sect2");

    // Random sequences
    for (int it = 0; it < 40; it++) begin
      int s, vs, e;
      bit q, legal;
      logic [7:0] code;
      s    = int'($urandom_range(0, NS + 2));
      q    = ($urandom_range(0, 3) != 0);
      code = ($urandom_range(0, 4) != 0) ? 8'h60 : 8'h64;
      legal = q && (code == 8'h60) && (s < NS);
      protect(s, q, code, legal ? PC : 0, "R3 random busy length");
      if (legal) exp_prot[s] = 1'b1;
      vs = int'($urandom_range(0, NS - 1));
      e  = legal ? int'(exp_prot[vs]) : 0;
      verify(vs, e, "R5 random verify");
    end

    finish_run();
  end
endmodule